// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides whether a regulated output sits inside its valid band. Every clock it takes a digital feedback sample and a digital reference code. It compares the sample against four levels, each a fixed per-mille fraction of the reference. The upper edge and the lower edge of the window each have their own trip level and their own, tighter, recovery level. This hysteresis keeps a sample that wanders between the two levels from toggling the result.

The result is an active-high good flag, the digital form of an open-drain pin being released. The flag is registered. It also needs three control inputs: the enable must be high, the shutdown request must be low, and the soft-start-done input must be high. Dropping the enable pulls the flag low in the same cycle, without waiting for a clock edge.

Top module: `pg_window_mon`

## Requirements
- R1: An over-limit fault is set when fb_code*1000 > ref_code*1110. At exactly 111.0 % of the reference the fault is not set.
- R2: A set over-limit fault stays set until fb_code*1000 <= ref_code*1075. It clears on that sample.
- R3: An under-limit fault is set when fb_code*1000 < ref_code*890. At exactly 89.0 % of the reference the fault is not set.
- R4: A set under-limit fault stays set until fb_code*1000 >= ref_code*925. It clears on that sample.
- R5: pg_good is 1 only when all of the following hold for the inputs sampled at the previous rising edge: neither fault is set, en = 1, shdn = 0 and ss_done = 1. A change at those inputs reaches pg_good one clock later.
- R6: While en = 0, pg_good is 0. The drop follows en combinationally, in the same cycle.
- R7: An active-low rst_n clears both fault states and drives pg_good to 0.
- R8: A sample that lies between a trip level and its recovery level never changes the flag. The flag keeps whatever value the last crossing gave it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable |
| shdn | input | 1 | Shutdown request, active high |
| ss_done | input | 1 | Soft-start finished successfully |
| fb_code | input | FB_W | Feedback sample |
| ref_code | input | REF_W | Reference code |
| pg_good | output | 1 | Output is in regulation, active high |

## Verification
The feedback is swept upward and downward one code at a time across every level. The sweeps use two reference codes, so a level placed one code wrong, or a strict comparison swapped for an inclusive one, shows up as a single wrong sample. Reversing the sweep inside each hysteresis band separates a window that holds its state from one that recomputes the flag every cycle. The control inputs are stepped one at a time while the feedback sits inside the window, which tests each gating term on its own. The enable is also dropped between clock edges to show that it acts without waiting for an edge.

// File: rtl/pg_win_pkg.sv
package pg_win_pkg;
    localparam int SCALE_PM   = 1000;
    localparam int OV_TRIP_PM = 1110;
    localparam int OV_REC_PM  = 1075;
    localparam int UV_TRIP_PM = 890;
    localparam int UV_REC_PM  = 925;
    localparam int PM_BITS    = 11;

    typedef struct packed {
        logic ov;
        logic uv;
        logic pg;
    } pg_state_t;
endpackage

// File: rtl/pg_thresh_cmp.sv
module pg_thresh_cmp
    import pg_win_pkg::*;
#(
    parameter int FB_W  = 12,
    parameter int REF_W = 12
) (
    input  logic [FB_W-1:0]  fb_code,
    input  logic [REF_W-1:0] ref_code,
    output logic             ov_trip,
    output logic             ov_rec,
    output logic             uv_trip,
    output logic             uv_rec
);
    localparam int PW = ((FB_W > REF_W) ? FB_W : REF_W) + PM_BITS;
    localparam int NLVL = 4;
    localparam int LVL_PM [NLVL] = '{OV_TRIP_PM, OV_REC_PM, UV_TRIP_PM, UV_REC_PM};

    logic [PW-1:0] fb_scaled;
    logic [PW-1:0] lvl [NLVL];

    assign fb_scaled = PW'(fb_code) * PW'(SCALE_PM);

    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        assign lvl[i] = PW'(ref_code) * PW'(LVL_PM[i]);
    end

    assign ov_trip = fb_scaled >  lvl[0];
    assign ov_rec  = fb_scaled <= lvl[1];
    assign uv_trip = fb_scaled <  lvl[2];
    assign uv_rec  = fb_scaled >= lvl[3];
endmodule

// File: rtl/pg_hyst_next.sv
module pg_hyst_next (
    input  logic flag_q,
    input  logic trip,
    input  logic rec,
    output logic flag_d
);
    always_comb begin
        if (flag_q) flag_d = ~rec;
        else        flag_d = trip;
    end
endmodule

// File: rtl/pg_window_mon.sv
module pg_window_mon
    import pg_win_pkg::*;
#(
    parameter int FB_W  = 12,
    parameter int REF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             shdn,
    input  logic             ss_done,
    input  logic [FB_W-1:0]  fb_code,
    input  logic [REF_W-1:0] ref_code,
    output logic             pg_good
);
    pg_state_t state_d, state_q;
    logic ov_trip, ov_rec, uv_trip, uv_rec;
    logic ov_nxt, uv_nxt;

    pg_thresh_cmp #(.FB_W(FB_W), .REF_W(REF_W)) u_cmp (
        .fb_code (fb_code),
        .ref_code(ref_code),
        .ov_trip (ov_trip),
        .ov_rec  (ov_rec),
        .uv_trip (uv_trip),
        .uv_rec  (uv_rec)
    );

    pg_hyst_next u_ov (.flag_q(state_q.ov), .trip(ov_trip), .rec(ov_rec), .flag_d(ov_nxt));
    pg_hyst_next u_uv (.flag_q(state_q.uv), .trip(uv_trip), .rec(uv_rec), .flag_d(uv_nxt));

    always_comb begin
        state_d    = state_q;
        state_d.ov = ov_nxt;
        state_d.uv = uv_nxt;
        state_d.pg = ~ov_nxt & ~uv_nxt & en & ~shdn & ss_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pg_good = state_q.pg & en;
endmodule

// File: rtl/pg_window_mon_chk.sv
module pg_window_mon_chk
    import pg_win_pkg::*;
#(
    parameter int FB_W  = 12,
    parameter int REF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             shdn,
    input logic             ss_done,
    input logic [FB_W-1:0]  fb_code,
    input logic [REF_W-1:0] ref_code,
    input logic             pg_good
);
    localparam int CW = ((FB_W > REF_W) ? FB_W : REF_W) + PM_BITS;
    logic [CW-1:0] fb_k, ov_k, uv_k;
    assign fb_k = CW'(fb_code) * CW'(SCALE_PM);
    assign ov_k = CW'(ref_code) * CW'(OV_TRIP_PM);
    assign uv_k = CW'(ref_code) * CW'(UV_TRIP_PM);

    a_r6_en_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pg_good);

    a_r5_ctrl_needed: assert property (@(posedge clk) disable iff (!rst_n)
        pg_good |-> ($past(ss_done) && !$past(shdn) && $past(en)));

    a_r1_over_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fb_k > ov_k) |-> !pg_good);

    a_r3_under_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fb_k < uv_k) |-> !pg_good);

    a_r7_reset_low: assert property (@(posedge clk)
        !rst_n |-> !pg_good);
endmodule

bind pg_window_mon pg_window_mon_chk #(.FB_W(FB_W), .REF_W(REF_W)) u_chk (.*);

// File: tb/pg_window_mon_tb.sv
`timescale 1ns/1ps
module pg_window_mon_tb;
    localparam int FB_W = 12;
    localparam int REF_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, shdn = 1'b0, ss_done = 1'b0;
    logic [FB_W-1:0]  fb_code = '0;
    logic [REF_W-1:0] ref_code = '0;
    logic pg_good;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    bit ov_m = 1'b0, uv_m = 1'b0;

    always #10 clk = ~clk;

    pg_window_mon #(.FB_W(FB_W), .REF_W(REF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .shdn(shdn), .ss_done(ss_done),
        .fb_code(fb_code), .ref_code(ref_code), .pg_good(pg_good)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input int fb, input int rf, input bit e, input bit s,
                         input bit ss, input string tag);
        longint f1k;
        item_t it;
        @(negedge clk);
        fb_code = FB_W'(fb); ref_code = REF_W'(rf);
        en = e; shdn = s; ss_done = ss;
        f1k = longint'(fb) * 1000;
        ov_m = ov_m ? !(f1k <= longint'(rf) * 1075) : (f1k > longint'(rf) * 1110);
        uv_m = uv_m ? !(f1k >= longint'(rf) * 925)  : (f1k < longint'(rf) * 890);
        it.exp = !ov_m && !uv_m && e && !s && ss;
        it.tag = tag;
        @(posedge clk);
        #1;
        sb_q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ov_m = 1'b0; uv_m = 1'b0;
        @(negedge clk);
        check(pg_good, 1'b0, "R7 reset holds flag low");
        rst_n = 1'b1;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(pg_good, it.exp, it.tag);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        do_reset();
        // R5 nominal in-window with all gates open
        apply(1000, 1000, 1, 0, 1, "R5 nominal good");
        // upward sweep across the upper edge
        apply(1110, 1000, 1, 0, 1, "R1 at 111.0% not tripped");
        apply(1111, 1000, 1, 0, 1, "R1 above 111% trips");
        apply(1100, 1000, 1, 0, 1, "R8 upper band holds fault");
        apply(1076, 1000, 1, 0, 1, "R2 above 107.5% still held");
        apply(1075, 1000, 1, 0, 1, "R2 at 107.5% clears");
        apply(1100, 1000, 1, 0, 1, "R8 upper band stays good");
        apply(1000, 1000, 1, 0, 1, "R5 back in window");
        // downward sweep across the lower edge
        apply(890, 1000, 1, 0, 1, "R3 at 89.0% not tripped");
        apply(889, 1000, 1, 0, 1, "R3 below 89% trips");
        apply(910, 1000, 1, 0, 1, "R8 lower band holds fault");
        apply(924, 1000, 1, 0, 1, "R4 below 92.5% still held");
        apply(925, 1000, 1, 0, 1, "R4 at 92.5% clears");
        apply(900, 1000, 1, 0, 1, "R8 lower band stays good");
        // gating inputs one at a time
        apply(1000, 1000, 1, 0, 0, "R5 soft-start pending");
        apply(1000, 1000, 1, 1, 1, "R5 shutdown forces low");
        apply(1000, 1000, 0, 0, 1, "R6 enable low");
        apply(1000, 1000, 1, 0, 1, "R5 gates reopened");
        // second reference code
        apply(888, 800, 1, 0, 1, "R1 ref800 at limit");
        apply(889, 800, 1, 0, 1, "R1 ref800 trip");
        apply(861, 800, 1, 0, 1, "R2 ref800 held");
        apply(860, 800, 1, 0, 1, "R2 ref800 clear");
        apply(712, 800, 1, 0, 1, "R3 ref800 at limit");
        apply(711, 800, 1, 0, 1, "R3 ref800 trip");
        apply(739, 800, 1, 0, 1, "R4 ref800 held");
        apply(740, 800, 1, 0, 1, "R4 ref800 clear");
        // R6: enable drop acts between edges
        apply(800, 800, 1, 0, 1, "R5 good before enable drop");
        @(negedge clk);
        #2;
        check(pg_good, 1'b1, "R6 flag high before drop");
        en = 1'b0;
        #1;
        check(pg_good, 1'b0, "R6 same-cycle drop");
        // R7: reset clears a held fault
        apply(1200, 1000, 1, 0, 1, "R1 trip before reset");
        apply(1090, 1000, 1, 0, 1, "R8 held before reset");
        do_reset();
        apply(1090, 1000, 1, 0, 1, "R7 fault cleared by reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule